// File: doc/BRIEF.md
# Dual-Channel Register-Mapped GPIO Controller

This block is a general-purpose I/O peripheral with one or two channels. Each channel has up to 32 pins. A simple 32-bit register bus reaches a data register and a direction register for each channel. The same bus reaches a small interrupt group, and that group drives one interrupt line. Each direction bit selects whether its pin is driven from the stored output value or left as an input. When a pin is an input, the controller synchronizes its pad value before software reads it.

Change detection works per channel, not per pin. When any input-direction pin of a channel changes, that channel raises a sticky status bit. Software reads the status and writes the same value back to clear it. The interrupt line is the OR of the enabled status bits, qualified by a global enable. Parameters set the width of each channel, whether the second channel exists, and the reset values of the direction and output data.

Top module: `gpio_dual_ctrl`

## Requirements
- R1: After reset, every direction bit equals its parameter default (all ones, meaning input, unless overridden). Output data equals its parameter default. Every pin output enable is 0. Interrupt status, interrupt enable and the global enable all read 0, and the interrupt line is low.
- R2: A direction bit of 1 makes its pin an input, with the output enable low. A direction bit of 0 drives the pin output enable high, and the pin output carries the stored data bit. The pin output always shows the stored data register.
- R3: Reading a data register returns the synchronized pin value for input bits and the stored value for output bits. A pin change is visible on the second rising edge after it. Bits at or above the channel width read as 0.
- R4: Channel 0 data is at byte address 0x000 and its direction at 0x004. Channel 1 data is at 0x008 and its direction at 0x00C. A write to one channel leaves the other channel unchanged.
- R5: Interrupt status is at byte address 0x120, with bit 0 for channel 0 and bit 1 for channel 1. A status bit sets on the third rising edge after a pin change, when that pin is an input. It then stays set. Pin changes on output-direction bits set nothing.
- R6: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new change is detected in the same cycle as a clear, the bit stays set.
- R7: Interrupt enable is at byte address 0x128, with the same bit positions as the status register. The global enable is at byte address 0x11C. The interrupt line is high exactly when the global enable is set and some channel has both its status bit and its enable bit set.
- R8: Only bit 31 of the global enable register is stored. Its other bits read as 0.
- R9: Addresses outside the listed registers, including addresses that are not word aligned, read as 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational from registers) |
| pin_in0 | input | W0 | Channel 0 pad inputs |
| pin_out0 | output | W0 | Channel 0 pad output values |
| pin_oe0 | output | W0 | Channel 0 output enables (1 = drive) |
| pin_in1 | input | W1 | Channel 1 pad inputs |
| pin_out1 | output | W1 | Channel 1 pad output values |
| pin_oe1 | output | W1 | Channel 1 output enables (1 = drive) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a status clear landing in the same cycle as a freshly detected change. The bench counts the synchronizer stages exactly. It toggles an input pin on a falling edge, waits two falling edges, and then presents the clear write so that it lands on the edge where the status bit sets. A second hard case is a pin toggling while its direction is output. That toggle must change neither the readback nor the status, so the bench sets up mixed-direction channels before it drives such a toggle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_DAT0 = 9'h000;
  localparam logic [ADDR_W-1:0] A_DIR0 = 9'h004;
  localparam logic [ADDR_W-1:0] A_DAT1 = 9'h008;
  localparam logic [ADDR_W-1:0] A_DIR1 = 9'h00C;
  localparam logic [ADDR_W-1:0] A_GIE  = 9'h11C;
  localparam logic [ADDR_W-1:0] A_STS  = 9'h120;
  localparam logic [ADDR_W-1:0] A_IEN  = 9'h128;

  localparam int GIE_BIT = 31;
  localparam int NCH     = 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DAT0, SEL_DIR0, SEL_DAT1, SEL_DIR1, SEL_GIE, SEL_STS, SEL_IEN
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= 1'b0;
      st2_q <= 1'b0;
    end else begin
      st1_q <= 1'b1;
      st2_q <= st1_q;
    end
  end

  assign rst_n_sync = st2_q;
endmodule

// File: rtl/gpio_chan.sv
module gpio_chan #(
  parameter int          W    = 32,
  parameter logic [31:0] DOUT = 32'h0,
  parameter logic [31:0] TRI  = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dat_we,
  input  logic         dir_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] rd_dir,
  output logic         chg
);
  localparam logic [W-1:0] DOUT_RST = DOUT[W-1:0];
  localparam logic [W-1:0] TRI_RST  = TRI[W-1:0];

  logic [W-1:0] dout_q, dout_d;
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_comb begin
    dout_d = dout_q;
    dir_d  = dir_q;
    if (dat_we) dout_d = wdata;
    if (dir_we) dir_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= DOUT_RST;
      dir_q  <= TRI_RST;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign pin_out = dout_q;
  assign pin_oe  = ~dir_q;
  assign rd_dir  = dir_q;
  assign rd_data = (s2_q & dir_q) | (dout_q & ~dir_q);
  assign chg     = |((s2_q ^ prev_q) & dir_q);

  // R2
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> (pin_oe == ~$past(wdata)));

  // R2
  dat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we |=> (pin_out == $past(wdata)));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gie_we,
  input  logic         ien_we,
  input  logic         sts_we,
  input  logic         gie_wbit,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] chg,
  output logic         gie,
  output logic [N-1:0] ien,
  output logic [N-1:0] sts,
  output logic         irq
);
  logic         gie_q, gie_d;
  logic [N-1:0] ien_q, ien_d;
  logic [N-1:0] sts_q, sts_d;
  logic [N-1:0] clr;

  always_comb begin
    gie_d = gie_q;
    ien_d = ien_q;
    clr   = sts_we ? wbits : '0;
    if (gie_we) gie_d = gie_wbit;
    if (ien_we) ien_d = wbits;
    sts_d = (sts_q & ~clr) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      gie_q <= gie_d;
      ien_q <= ien_d;
      sts_q <= sts_d;
    end
  end

  assign gie = gie_q;
  assign ien = ien_q;
  assign sts = sts_q;
  assign irq = gie_q & |(sts_q & ien_q);

  for (genvar c = 0; c < N; c++) begin : g_chk
    // R5
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[c] && !(sts_we && wbits[c])) |=> sts_q[c]);
    // R6
    sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && wbits[c] && !chg[c]) |=> !sts_q[c]);
    // R5
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg[c] |=> sts_q[c]);
  end

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_we && !gie_wbit) |=> !irq);
endmodule

// File: rtl/gpio_dual_ctrl.sv
module gpio_dual_ctrl
  import gpio_pkg::*;
#(
  parameter bit          DUAL  = 1'b1,
  parameter int          W0    = 32,
  parameter int          W1    = 32,
  parameter logic [31:0] DOUT0 = 32'h0,
  parameter logic [31:0] DOUT1 = 32'h0,
  parameter logic [31:0] TRI0  = 32'hFFFF_FFFF,
  parameter logic [31:0] TRI1  = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [W0-1:0]     pin_in0,
  output logic [W0-1:0]     pin_out0,
  output logic [W0-1:0]     pin_oe0,
  input  logic [W1-1:0]     pin_in1,
  output logic [W1-1:0]     pin_out1,
  output logic [W1-1:0]     pin_oe1,
  output logic              irq
);
  logic     rst_ni;
  reg_sel_e sel;
  logic     wr;

  logic [W0-1:0] rd_dat0, rd_dir0;
  logic [W1-1:0] rd_dat1, rd_dir1;
  logic [NCH-1:0] chg;
  logic           gie;
  logic [NCH-1:0] ien, sts;

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  always_comb begin
    unique case (bus_addr)
      A_DAT0:  sel = SEL_DAT0;
      A_DIR0:  sel = SEL_DIR0;
      A_DAT1:  sel = DUAL ? SEL_DAT1 : SEL_NONE;
      A_DIR1:  sel = DUAL ? SEL_DIR1 : SEL_NONE;
      A_GIE:   sel = SEL_GIE;
      A_STS:   sel = SEL_STS;
      A_IEN:   sel = SEL_IEN;
      default: sel = SEL_NONE;
    endcase
  end

  assign wr = bus_en & bus_we;

  gpio_chan #(.W(W0), .DOUT(DOUT0), .TRI(TRI0)) u_ch0 (
    .clk(clk), .rst_n(rst_ni),
    .dat_we(wr && sel == SEL_DAT0), .dir_we(wr && sel == SEL_DIR0),
    .wdata(bus_wdata[W0-1:0]), .pin_in(pin_in0),
    .pin_out(pin_out0), .pin_oe(pin_oe0),
    .rd_data(rd_dat0), .rd_dir(rd_dir0), .chg(chg[0])
  );

  if (DUAL) begin : g_ch1
    gpio_chan #(.W(W1), .DOUT(DOUT1), .TRI(TRI1)) u_ch1 (
      .clk(clk), .rst_n(rst_ni),
      .dat_we(wr && sel == SEL_DAT1), .dir_we(wr && sel == SEL_DIR1),
      .wdata(bus_wdata[W1-1:0]), .pin_in(pin_in1),
      .pin_out(pin_out1), .pin_oe(pin_oe1),
      .rd_data(rd_dat1), .rd_dir(rd_dir1), .chg(chg[1])
    );
  end else begin : g_no_ch1
    assign pin_out1 = '0;
    assign pin_oe1  = '0;
    assign rd_dat1  = '0;
    assign rd_dir1  = '0;
    assign chg[1]   = 1'b0;
  end

  gpio_irq #(.N(NCH)) u_irq (
    .clk(clk), .rst_n(rst_ni),
    .gie_we(wr && sel == SEL_GIE),
    .ien_we(wr && sel == SEL_IEN),
    .sts_we(wr && sel == SEL_STS),
    .gie_wbit(bus_wdata[GIE_BIT]),
    .wbits(bus_wdata[NCH-1:0]),
    .chg(chg),
    .gie(gie), .ien(ien), .sts(sts), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_DAT0: bus_rdata = 32'(rd_dat0);
      SEL_DIR0: bus_rdata = 32'(rd_dir0);
      SEL_DAT1: bus_rdata = 32'(rd_dat1);
      SEL_DIR1: bus_rdata = 32'(rd_dir1);
      SEL_GIE:  bus_rdata[GIE_BIT] = gie;
      SEL_STS:  bus_rdata[NCH-1:0] = sts;
      SEL_IEN:  bus_rdata[NCH-1:0] = ien;
      default:  bus_rdata = '0;
    endcase
  end

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_addr == A_DAT1) |-> ((bus_rdata >> W1) == '0));

  // R8
  gie_bits_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_addr == A_GIE) |-> (bus_rdata[GIE_BIT-1:0] == '0));
endmodule

// File: tb/sim_gpio_dual_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_dual_ctrl;
  localparam int W0 = 32;
  localparam int W1 = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_en, bus_we;
  logic [8:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [W0-1:0] pin_in0, pin_out0, pin_oe0;
  logic [W1-1:0] pin_in1, pin_out1, pin_oe1;
  logic          irq;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t q[$];
  bit   rd_pending = 1'b0;
  int   checks = 0;
  int   errors = 0;

  always #2 clk = ~clk;

  gpio_dual_ctrl #(.DUAL(1'b1), .W0(W0), .W1(W1), .DOUT1(32'h0A5)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in0(pin_in0), .pin_out0(pin_out0), .pin_oe0(pin_oe0),
    .pin_in1(pin_in1), .pin_out1(pin_out1), .pin_oe1(pin_oe1),
    .irq(irq)
  );

  // Monitor: pops expectations as read results appear.
  always @(posedge clk) begin
    #1;
    if (rd_pending && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (bus_rdata !== e.exp) begin
        errors++;
        $display("FAIL %s: rdata=%08h expected=%08h", e.tag, bus_rdata, e.exp);
      end
    end
  end

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    q.push_back('{exp, tag});
    rd_pending = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; rd_pending = 1'b0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in0 = '0; pin_in1 = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(9'h004, 32'hFFFF_FFFF, "R1 dir0 reset");
    rd(9'h00C, 32'h0000_0FFF, "R1 dir1 reset");
    chk(32'(pin_oe0), 32'h0, "R1 oe0 reset");
    chk(32'(pin_out1), 32'h0A5, "R1 out1 default");
    chk({31'h0, irq}, 32'h0, "R1 irq reset");
    rd(9'h120, 32'h0, "R1 status reset");
    rd(9'h11C, 32'h0, "R1 gie reset");
    rd(9'h128, 32'h0, "R1 enable reset");

    // R2 / R4 mixed direction on channel 0
    wr(9'h004, 32'hFFFF_0000);
    wr(9'h000, 32'h1234_ABCD);
    chk(32'(pin_oe0), 32'h0000_FFFF, "R2 oe0 follows dir");
    chk(32'(pin_out0), 32'h1234_ABCD, "R2 out0 follows data");
    pin_in0 = 32'hBEEF_0000;
    idle(3);
    rd(9'h000, 32'hBEEF_ABCD, "R3 mixed readback");
    rd(9'h00C, 32'h0000_0FFF, "R4 ch1 dir untouched");

    // R3 width masking on channel 1
    wr(9'h008, 32'hFFFF_FFFF);
    wr(9'h00C, 32'h0);
    chk(32'(pin_out1), 32'h0000_0FFF, "R3 out1 truncated");
    chk(32'(pin_oe1), 32'h0000_0FFF, "R2 oe1 all drive");
    rd(9'h008, 32'h0000_0FFF, "R3 ch1 upper bits zero");
    wr(9'h00C, 32'hFFFF_FFFF);

    // clear status left from the channel 0 input change
    wr(9'h120, 32'h3);
    rd(9'h120, 32'h0, "R6 clear both");

    // R5 output-direction bit toggle is ignored
    pin_in0 = 32'hBEEF_0001;
    idle(4);
    rd(9'h120, 32'h0, "R5 output pin change ignored");
    rd(9'h000, 32'hBEEF_ABCD, "R3 output bit readback stored");
    pin_in1 = 12'h800;
    idle(4);
    rd(9'h120, 32'h2, "R5 ch1 status set");
    chk({31'h0, irq}, 32'h0, "R7 irq off without enables");

    // R7 / R8 gating
    wr(9'h128, 32'h2);
    chk({31'h0, irq}, 32'h0, "R7 irq off without gie");
    wr(9'h11C, 32'h8000_0000);
    chk({31'h0, irq}, 32'h1, "R7 irq on");
    rd(9'h11C, 32'h8000_0000, "R8 gie readback");
    wr(9'h11C, 32'h7FFF_FFFF);
    rd(9'h11C, 32'h0, "R8 only bit 31 stored");
    chk({31'h0, irq}, 32'h0, "R7 irq off after gie clear");
    wr(9'h11C, 32'h8000_0000);
    chk({31'h0, irq}, 32'h1, "R7 irq back on");
    wr(9'h128, 32'h1);
    chk({31'h0, irq}, 32'h0, "R7 irq off when enable mismatched");

    // R6 write-one-to-clear
    wr(9'h120, 32'h1);
    rd(9'h120, 32'h2, "R6 zero-status bit write keeps other");
    wr(9'h120, 32'h2);
    rd(9'h120, 32'h0, "R6 status cleared");
    pin_in0 = 32'h3EEF_0001;
    idle(4);
    rd(9'h120, 32'h1, "R5 ch0 status set");
    chk({31'h0, irq}, 32'h1, "R7 irq on ch0");

    // R6 clear colliding with new detection: set wins
    @(negedge clk);
    pin_in0 = 32'h7EEF_0001;
    @(negedge clk);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 9'h120; bus_wdata = 32'h1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    rd(9'h120, 32'h1, "R6 set wins over clear");
    wr(9'h120, 32'h1);
    rd(9'h120, 32'h0, "R6 final clear");
    chk({31'h0, irq}, 32'h0, "R7 irq low after clear");

    // R9 unmapped
    wr(9'h1FC, 32'hFFFF_FFFF);
    wr(9'h002, 32'h0);
    rd(9'h1FC, 32'h0, "R9 unmapped reads zero");
    rd(9'h001, 32'h0, "R9 unaligned reads zero");
    rd(9'h004, 32'hFFFF_0000, "R9 dir0 untouched");
    chk(32'(pin_out0), 32'h1234_ABCD, "R9 out0 untouched");

    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule